// File: doc/BRIEF.md
# Per-Channel Threshold Zero Suppressor

This block sits behind a front-end digitiser that sends one raw sample for every pad channel on every beam crossing. Each sample arrives with its channel number and crossing number. The block subtracts the channel's pedestal from the sample and compares the result with the channel's threshold. A sample that clears the threshold becomes one packed 64-bit word holding the channel, the crossing and the corrected amplitude. A sample that does not clear it is discarded. With the threshold near two noise sigma, only a small fraction of samples come out, so the block cuts the readout volume by a large factor.

A single-cycle write port fills two tables, one for pedestals and one for thresholds, with one entry per channel. Kept words go into a small first-in first-out buffer that absorbs bursts. The buffer drains through a valid/ready output. When the buffer is full, the input is stalled, so no accepted sample is ever lost.

Top module: `zs_suppressor`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1. Every pedestal and every threshold entry reads as 0.
- R2: The corrected amplitude is the low 14 bits of `inSample` minus the channel's pedestal. When the pedestal is larger than the sample, the result is 0. Bits 15:14 of `inSample` have no effect.
- R3: A sample is kept only when its corrected amplitude is strictly greater than the channel's threshold. A sample whose amplitude equals the threshold is discarded.
- R4: The output word holds the amplitude in bits 13:0, the crossing number in bits 26:14 and the channel number in bits 33:27. Bits 63:34 are 0.
- R5: A discarded sample produces no output word. Every kept sample produces exactly one output word.
- R6: Kept words leave in the order the samples were accepted. `inReady` is 0 while the buffer holds DEPTH (default 4) words. A sample is taken only on a cycle where `inValid` and `inReady` are both 1.
- R7: When `cfgWrite` is 1, `cfgData` is written to the pedestal table if `cfgSelThresh` is 0, or to the threshold table if it is 1, at entry `cfgChannel`. The new value applies from the next sample of that channel onwards. A sample of the same channel taken in the same cycle as the write still uses the old value.
- R8: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outWord` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A sample is offered |
| inReady | output | 1 | The block can take a sample |
| inChannel | input | 7 | Channel of the offered sample |
| inCrossing | input | 13 | Crossing number of the offered sample |
| inSample | input | 16 | Raw sample; only bits 13:0 are used |
| cfgWrite | input | 1 | Table write strobe |
| cfgSelThresh | input | 1 | Write target: 0 = pedestal table, 1 = threshold table |
| cfgChannel | input | 7 | Table entry to write |
| cfgData | input | 14 | Value to write |
| outValid | output | 1 | A kept word is offered |
| outReady | input | 1 | The consumer takes the offered word |
| outWord | output | 64 | Packed kept word |

## Verification
Two things can happen in the same cycle: a table write and an accepted sample that reads the same channel entry. The bench provokes this by raising `cfgWrite` in the cycle a sample of that channel is accepted. It then expects the outcome set by the old value, and the outcome set by the new value for the next sample of that channel. A second collision is the buffer filling while the output is stalled. The bench holds `outReady` low during a burst and checks three things: the stall on `inReady`, the frozen output word, and the complete, in-order stream once the output drains. A scoreboard built from its own copy of the tables checks every word.

// File: rtl/zs_pkg.sv
package zs_pkg;
  // Strobes that the control module hands to the datapath each cycle
  typedef struct packed {
    logic push;   // store the current kept word into the buffer
    logic pop;    // the consumer takes the head word
    logic wrPed;  // write a pedestal table entry
    logic wrThr;  // write a threshold table entry
  } zsStrobes_t;
endpackage

// File: rtl/zs_ctrl.sv
module zs_ctrl
  import zs_pkg::*;
(
  input  logic       inValid,
  input  logic       outReady,
  input  logic       keep,
  input  logic       full,
  input  logic       empty,
  input  logic       cfgWrite,
  input  logic       cfgSelThresh,
  output logic       inReady,
  output logic       outValid,
  output zsStrobes_t strobes
);
  // Stall the input only when the buffer has no room left
  assign inReady  = !full;
  assign outValid = !empty;

  always_comb begin
    strobes.push  = inValid && !full && keep;
    strobes.pop   = !empty && outReady;
    strobes.wrPed = cfgWrite && !cfgSelThresh;
    strobes.wrThr = cfgWrite && cfgSelThresh;
  end
endmodule

// File: rtl/zs_datapath.sv
module zs_datapath
  import zs_pkg::*;
#(
  parameter int CH_W   = 7,
  parameter int TS_W   = 13,
  parameter int AMP_W  = 14,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  zsStrobes_t        strobes,
  input  logic [CH_W-1:0]   inChannel,
  input  logic [TS_W-1:0]   inCrossing,
  input  logic [AMP_W-1:0]  inAmpRaw,
  input  logic [CH_W-1:0]   cfgChannel,
  input  logic [AMP_W-1:0]  cfgData,
  output logic              keep,
  output logic              full,
  output logic              empty,
  output logic [WORD_W-1:0] outWord
);
  localparam int NUM_CH = 1 << CH_W;
  localparam int PAD_W  = WORD_W - CH_W - TS_W - AMP_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [AMP_W-1:0] pedTab [NUM_CH];
  logic [AMP_W-1:0] thrTab [NUM_CH];

  // One register pair per channel entry
  for (genvar g = 0; g < NUM_CH; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pedTab[g] <= '0;
        thrTab[g] <= '0;
      end else begin
        if (strobes.wrPed && cfgChannel == CH_W'(g)) pedTab[g] <= cfgData;
        if (strobes.wrThr && cfgChannel == CH_W'(g)) thrTab[g] <= cfgData;
      end
    end
  end

  // The tables are read before this cycle's write lands, so a write and a
  // sample of the same channel in one cycle give the sample the old value
  logic [AMP_W-1:0]  pedCur, thrCur, ampCorr;
  logic [WORD_W-1:0] newWord;
  always_comb begin
    pedCur  = pedTab[inChannel];
    thrCur  = thrTab[inChannel];
    ampCorr = (inAmpRaw > pedCur) ? (inAmpRaw - pedCur) : '0;
    keep    = ampCorr > thrCur;
    newWord = {{PAD_W{1'b0}}, inChannel, inCrossing, ampCorr};
  end

  // Burst buffer
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.push) wrPtr <= nextPtr(wrPtr);
      if (strobes.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign outWord = mem[rdPtr];
endmodule

// File: rtl/zs_suppressor.sv
module zs_suppressor
  import zs_pkg::*;
#(
  parameter int CH_W   = 7,
  parameter int TS_W   = 13,
  parameter int AMP_W  = 14,
  parameter int RAW_W  = 16,
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [CH_W-1:0]   inChannel,
  input  logic [TS_W-1:0]   inCrossing,
  input  logic [RAW_W-1:0]  inSample,
  input  logic              cfgWrite,
  input  logic              cfgSelThresh,
  input  logic [CH_W-1:0]   cfgChannel,
  input  logic [AMP_W-1:0]  cfgData,
  output logic              outValid,
  input  logic              outReady,
  output logic [WORD_W-1:0] outWord
);
  zsStrobes_t strobes;
  logic keep, full, empty;

  // The top bits of the sample field carry no amplitude
  logic unusedSampleHi;
  assign unusedSampleHi = ^inSample[RAW_W-1:AMP_W];

  zs_ctrl u_ctrl (
    .inValid     (inValid),
    .outReady    (outReady),
    .keep        (keep),
    .full        (full),
    .empty       (empty),
    .cfgWrite    (cfgWrite),
    .cfgSelThresh(cfgSelThresh),
    .inReady     (inReady),
    .outValid    (outValid),
    .strobes     (strobes)
  );

  zs_datapath #(
    .CH_W(CH_W), .TS_W(TS_W), .AMP_W(AMP_W), .WORD_W(WORD_W), .DEPTH(DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inChannel (inChannel),
    .inCrossing(inCrossing),
    .inAmpRaw  (inSample[AMP_W-1:0]),
    .cfgChannel(cfgChannel),
    .cfgData   (cfgData),
    .keep      (keep),
    .full      (full),
    .empty     (empty),
    .outWord   (outWord)
  );
endmodule

// File: rtl/zs_checker.sv
module zs_checker #(
  parameter int WORD_W = 64,
  parameter int DEPTH  = 4,
  parameter int USED_W = 34
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [WORD_W-1:0] outWord,
  input logic              push,
  input logic              pop
);
  localparam int CNT_W = $clog2(DEPTH + 2);
  logic [CNT_W-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rstN) shadow <= '0;
    else shadow <= shadow + CNT_W'(push) - CNT_W'(pop);
  end

  // R6: a push only with an accepted input handshake
  assert_push_handshake_R6: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (inValid && inReady));

  // R6: occupancy never exceeds the buffer depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    shadow <= CNT_W'(DEPTH));

  // R5: a word is offered exactly when a kept sample is pending
  assert_valid_tracks_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid == (shadow != '0));

  // R4: reserved bits are zero in every offered word
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outWord[WORD_W-1:USED_W] == '0));

  // R8: a stalled word holds still
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outWord)));
endmodule

bind zs_suppressor zs_checker #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .USED_W(CH_W + TS_W + AMP_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outReady(outReady),
  .outWord (outWord),
  .push    (strobes.push),
  .pop     (strobes.pop)
);

// File: tb/zs_suppressor_tb.sv
module zs_suppressor_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        inValid = 0;
  logic        inReady;
  logic [6:0]  inChannel = 0;
  logic [12:0] inCrossing = 0;
  logic [15:0] inSample = 0;
  logic        cfgWrite = 0;
  logic        cfgSelThresh = 0;
  logic [6:0]  cfgChannel = 0;
  logic [13:0] cfgData = 0;
  logic        outValid;
  logic        outReady = 1;
  logic [63:0] outWord;

  int checks = 0;
  int errors = 0;
  int pedModel [128];
  int thrModel [128];
  logic [63:0] expQ [$];
  bit randReady = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] rdyLfsr = 16'h1D2B;

  always #5 clk = ~clk;

  zs_suppressor u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inChannel(inChannel), .inCrossing(inCrossing), .inSample(inSample),
    .cfgWrite(cfgWrite), .cfgSelThresh(cfgSelThresh), .cfgChannel(cfgChannel),
    .cfgData(cfgData), .outValid(outValid), .outReady(outReady), .outWord(outWord)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called just after a rising edge; pushes the expected word first
  task automatic sendSample(input int ch, input int cr, input logic [15:0] raw,
                            input bit doCfg = 0, input bit sel = 0,
                            input int cfgCh = 0, input int val = 0);
    int amp;
    amp = (int'(raw[13:0]) > pedModel[ch]) ? int'(raw[13:0]) - pedModel[ch] : 0;
    if (amp > thrModel[ch])
      expQ.push_back({30'b0, 7'(ch), 13'(cr), 14'(amp)});
    inValid = 1; inChannel = 7'(ch); inCrossing = 13'(cr); inSample = raw;
    cfgWrite = doCfg; cfgSelThresh = sel; cfgChannel = 7'(cfgCh); cfgData = 14'(val);
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 0; cfgWrite = 0;
    if (doCfg) begin
      if (sel) thrModel[cfgCh] = val; else pedModel[cfgCh] = val;
    end
  endtask

  task automatic writeCfg(input bit sel, input int ch, input int val);
    cfgWrite = 1; cfgSelThresh = sel; cfgChannel = 7'(ch); cfgData = 14'(val);
    @(posedge clk); #1;
    cfgWrite = 0;
    if (sel) thrModel[ch] = val; else pedModel[ch] = val;
  endtask

  // Monitor: a word offered and taken at the coming edge is compared here
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) check(0, "R5 unexpected word", outWord, 64'h0);
      else begin
        logic [63:0] e;
        e = expQ.pop_front();
        check(outWord == e, "R2/R3/R4/R6 word", outWord, e);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (randReady) begin
      rdyLfsr = {rdyLfsr[14:0], rdyLfsr[15] ^ rdyLfsr[13] ^ rdyLfsr[12] ^ rdyLfsr[10]};
      outReady = rdyLfsr[0] | rdyLfsr[3];
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    for (int i = 0; i < 128; i++) begin pedModel[i] = 0; thrModel[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(outValid == 0, "R1 outValid after reset", 64'(outValid), 64'd0);
    check(inReady == 1, "R1 inReady after reset", 64'(inReady), 64'd1);
    @(posedge clk); #1;

    // R1/R3: zero tables; amplitude 0 is not above 0, amplitude 5 is
    sendSample(1, 10, 16'd0);
    sendSample(1, 11, 16'd5);

    // R2/R3: pedestal 100, threshold 20
    writeCfg(0, 3, 100);
    writeCfg(1, 3, 20);
    sendSample(3, 20, 16'd120);            // amplitude equal to threshold: dropped
    sendSample(3, 21, 16'd121);            // kept, amplitude 21
    sendSample(3, 22, 16'd50);             // saturates to 0: dropped
    sendSample(3, 23, 16'hC000 | 16'd121); // top bits ignored: amplitude 21

    // R4: extreme field values
    writeCfg(1, 127, 16382);
    sendSample(127, 8191, 16'h3FFF);

    // R7: a write and a sample of the same channel in one cycle
    sendSample(5, 30, 16'd500, 1, 1, 5, 1000); // old threshold 0: kept
    sendSample(5, 31, 16'd500);                // new threshold 1000: dropped
    sendSample(5, 32, 16'd1001);               // kept

    repeat (4) @(posedge clk); #1;
    check(expQ.size() == 0, "R5 drained after directed cases", 64'(expQ.size()), 64'd0);

    // R6/R8: backpressure with the output stalled
    outReady = 0;
    fork
      for (int k = 0; k < 6; k++) sendSample(9, 100 + k, 16'(200 + k));
      begin
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(inReady == 0, "R6 inReady low when buffer full", 64'(inReady), 64'd0);
        check(outValid == 1, "R8 outValid held", 64'(outValid), 64'd1);
        held = outWord;
        @(negedge clk);
        check(outWord == held, "R8 word stable while stalled", outWord, held);
        @(posedge clk); #1;
        outReady = 1;
      end
    join
    repeat (8) @(posedge clk); #1;
    check(expQ.size() == 0, "R6 no loss after backpressure", 64'(expQ.size()), 64'd0);

    // R2/R3/R5/R6: mixed traffic with a random consumer
    for (int c = 0; c < 16; c++) begin
      writeCfg(0, c, c * 300);
      writeCfg(1, c, c * 200 + 500);
    end
    randReady = 1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendSample(int'(lfsr[3:0]), n, lfsr ^ 16'(n * 37));
    end
    randReady = 0;
    #1 outReady = 1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(expQ.size() == 0, "R5 every kept sample delivered", 64'(expQ.size()), 64'd0);
    check(outValid == 0, "R5 no extra words", 64'(outValid), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule